// File: doc/BRIEF.md
# Programmable Event Channel Router

The router carries single-bit events from producer blocks to consumer blocks over a set of twelve asynchronous channels. Each channel picks one producer signal as its primary operand A. Software can also force a channel high, either for as long as a level bit is set or for a single cycle through a write-only pulse register. The upper four channels are programmable two-input logic cells. Each one takes a second operand B from another channel and combines A and B through a 4-bit truth-table code.

Every channel output is registered once. A value register samples those outputs one cycle later so software can read them back. Each consumer port selects one async channel. The last consumer ports also select one of four externally supplied sync channels, and that selection is independent of the async one. Registers are reached through a simple word-addressed write port and a combinational read port.

Top module: `evr_router`

## Requirements
- R1: Reset (synchronous, active high) clears every register. After reset all channel outputs, the value register, the level register, every control word and every consumer select read as 0.
- R2: Register map by word address: 0x00 level (read-write, bits 11:0), 0x01 pulse (write-only, reads 0), 0x02 value (read-only, writes ignored). Channel n control word is at 0x10+n, with signal select [2:0], source select [14:8], function [19:16] and aux select [27:24]; other bits read 0. Consumer k select word is at 0x20+k, with async select [3:0]. Consumers 4 and 5 also have a sync select at [9:8], and all other bits read 0.
- R3: Operand A of a channel is producer input bit source*7 + signal-1. A is 0 when the signal select is 0 or the source select is 4 or higher.
- R4: Channels 0 to 7 output A only. Their function and aux fields have no effect.
- R5: Channels 8 to 11 output bit {A,B} of the function code, where {1,1} selects bit 3 and {0,0} selects bit 0. For example, 8 is AND, 6 is XOR, 0 is constant 0 and 15 is constant 1.
- R6: Operand B is selected by the aux select. Values 0 to 7 give that channel's unregistered value in the same cycle. Values 8 to 11, including the channel's own index, give that channel's registered output. Values 12 to 15 give 0.
- R7: A level bit is ORed into its channel for as long as it is set. It reaches the channel output one cycle after the level write takes effect.
- R8: Writing 1 to a pulse bit drives that channel output high for exactly one cycle, in the cycle that follows the write edge.
- R9: The value register holds the channel outputs delayed by one cycle.
- R10: Consumer async output k equals channel output[select]. A select of 12 to 15 gives 0.
- R11: Sync consumer output m equals sync input[select], combinationally, and is independent of the async select.
- R12: A change of producer input appears on the channel output after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| prod_sig_i | input | 28 | Producer signals, 7 per producer, 4 producers |
| sync_ch_i | input | 4 | Sync channel inputs |
| chan_o | output | 12 | Registered channel outputs |
| cons_async_o | output | 6 | Consumer async outputs |
| cons_sync_o | output | 2 | Sync outputs of consumers 4 and 5 |

## Verification
A register write takes effect at the edge that ends its strobe cycle. A pulse is visible on the channel output right after that same edge. A level bit, a new control word or a changed producer input shows on the channel output one edge later, and the value register lags the output by one further edge. Consumer outputs and read data are combinational. The bench drives every input and samples every output at the falling clock edge. After each stimulus it steps exactly the number of rising edges the requirement gives before it compares, so a result that arrives one cycle early or late fails.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int REG_W      = 32;
    localparam int REG_ADDR_W = 6;

    localparam int SIG_LSB = 0;
    localparam int SIG_W   = 3;
    localparam int SRC_LSB = 8;
    localparam int SRC_W   = 7;
    localparam int FN_LSB  = 16;
    localparam int FN_W    = 4;
    localparam int AUX_LSB = 24;
    localparam int AUX_W   = 4;

    localparam int CSEL_LSB = 0;
    localparam int CSEL_W   = 4;
    localparam int SSEL_LSB = 8;
    localparam int SSEL_W   = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_LEVEL     = 6'h00;
    localparam logic [REG_ADDR_W-1:0] ADDR_PULSE     = 6'h01;
    localparam logic [REG_ADDR_W-1:0] ADDR_VALUE     = 6'h02;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL_BASE = 6'h10;
    localparam logic [REG_ADDR_W-1:0] ADDR_CONS_BASE = 6'h20;

    typedef enum logic [FN_W-1:0] {
        FN_ZERO     = 4'd0,
        FN_NOR      = 4'd1,
        FN_NA_AND_B = 4'd2,
        FN_NOT_A    = 4'd3,
        FN_A_AND_NB = 4'd4,
        FN_NOT_B    = 4'd5,
        FN_XOR      = 4'd6,
        FN_NAND     = 4'd7,
        FN_AND      = 4'd8,
        FN_XNOR     = 4'd9,
        FN_PASS_B   = 4'd10,
        FN_NA_OR_B  = 4'd11,
        FN_PASS_A   = 4'd12,
        FN_A_OR_NB  = 4'd13,
        FN_OR       = 4'd14,
        FN_ONE      = 4'd15
    } lut_fn_e;

    typedef struct packed {
        logic [AUX_W-1:0] aux;
        lut_fn_e          fn;
        logic [SRC_W-1:0] src;
        logic [SIG_W-1:0] sig;
    } chan_ctrl_t;

    function automatic chan_ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
        chan_ctrl_t c;
        c.sig = w[SIG_LSB +: SIG_W];
        c.src = w[SRC_LSB +: SRC_W];
        c.fn  = lut_fn_e'(w[FN_LSB +: FN_W]);
        c.aux = w[AUX_LSB +: AUX_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(chan_ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[SIG_LSB +: SIG_W] = c.sig;
        w[SRC_LSB +: SRC_W] = c.src;
        w[FN_LSB  +: FN_W]  = c.fn;
        w[AUX_LSB +: AUX_W] = c.aux;
        return w;
    endfunction

    // Truth-table lookup: bit index is {a,b}
    function automatic logic lut2(lut_fn_e fn, logic a, logic b);
        logic [FN_W-1:0] t;
        t = fn;
        return t[{a, b}];
    endfunction

endpackage

// File: rtl/evr_src_pick.sv
module evr_src_pick
    import evr_pkg::*;
#(
    parameter int NUM_PROD = 4,
    parameter int NUM_SIG  = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SIG_W-1:0]            sig_sel,
    input  logic [SRC_W-1:0]            src_sel,
    input  logic [NUM_PROD*NUM_SIG-1:0] prod_vec,
    output logic                        a_out
);

    always_comb begin
        a_out = 1'b0;
        for (int p = 0; p < NUM_PROD; p++) begin
            for (int s = 1; s <= NUM_SIG; s++) begin
                if (src_sel == SRC_W'(p) && sig_sel == SIG_W'(s)) begin
                    a_out = prod_vec[p*NUM_SIG + s - 1];
                end
            end
        end
    end

    // R3: an empty signal select never yields an active operand
    p_nosig_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (sig_sel == '0) |-> !a_out);

    // R3: out-of-range producer never yields an active operand
    p_nosrc_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(src_sel) >= NUM_PROD) |-> !a_out);

endmodule

// File: rtl/evr_pick_n.sv
module evr_pick_n #(
    parameter int N     = 12,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [N-1:0]     in_vec,
    output logic             out
);

    always_comb begin
        out = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i)) out = in_vec[i];
        end
    end

    generate
        if ((1 << SEL_W) > N) begin : g_range
            // R10 (also R6 for aux selection): select beyond the set gives 0
            p_out_of_range_zero_r10: assert property (@(posedge clk) disable iff (rst)
                (int'(sel) >= N) |-> !out);
        end
    endgenerate

    // R10/R11: an active output needs an active input
    p_out_needs_source_r10: assert property (@(posedge clk) disable iff (rst)
        out |-> (|in_vec));

endmodule

// File: rtl/evr_router.sv
module evr_router
    import evr_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int NUM_LOGIC = 4,
    parameter int NUM_PROD  = 4,
    parameter int NUM_SIG   = 7,
    parameter int NUM_SYNC  = 4,
    parameter int NUM_CONS  = 6,
    parameter int NUM_SCONS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [REG_ADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]            wr_data,
    input  logic [REG_ADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]            rd_data,
    input  logic [NUM_PROD*NUM_SIG-1:0] prod_sig_i,
    input  logic [NUM_SYNC-1:0]         sync_ch_i,
    output logic [NUM_CH-1:0]           chan_o,
    output logic [NUM_CONS-1:0]         cons_async_o,
    output logic [NUM_SCONS-1:0]        cons_sync_o
);

    localparam int FIRST_LOGIC = NUM_CH - NUM_LOGIC;
    localparam int FIRST_SCONS = NUM_CONS - NUM_SCONS;

    chan_ctrl_t           ctrl_q [NUM_CH];
    logic [CSEL_W-1:0]    csel_q [NUM_CONS];
    logic [SSEL_W-1:0]    ssel_q [NUM_SCONS];
    logic [NUM_CH-1:0]    level_q;
    logic [NUM_CH-1:0]    ch_q;
    logic [NUM_CH-1:0]    val_q;

    logic [NUM_CH-1:0]    pulse_now;
    logic [NUM_CH-1:0]    a_sel;
    logic [FIRST_LOGIC-1:0] plain_v;
    logic [NUM_LOGIC-1:0] logic_v;
    logic [NUM_CH-1:0]    b_pool;
    logic [NUM_CH-1:0]    ch_next;

    wire unused_wr_bits = ^{wr_data[31:28], wr_data[23:20], wr_data[15]};

    // ---------------- register writes ----------------
    assign pulse_now = (wr_en && wr_addr == ADDR_PULSE) ? wr_data[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            for (int i = 0; i < NUM_CH; i++)    ctrl_q[i] <= '0;
            for (int k = 0; k < NUM_CONS; k++)  csel_q[k] <= '0;
            for (int m = 0; m < NUM_SCONS; m++) ssel_q[m] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_LEVEL) level_q <= wr_data[NUM_CH-1:0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_CTRL_BASE + REG_ADDR_W'(i))
                    ctrl_q[i] <= unpack_ctrl(wr_data);
            end
            for (int k = 0; k < NUM_CONS; k++) begin
                if (wr_addr == ADDR_CONS_BASE + REG_ADDR_W'(k))
                    csel_q[k] <= wr_data[CSEL_LSB +: CSEL_W];
            end
            for (int m = 0; m < NUM_SCONS; m++) begin
                if (wr_addr == ADDR_CONS_BASE + REG_ADDR_W'(FIRST_SCONS + m))
                    ssel_q[m] <= wr_data[SSEL_LSB +: SSEL_W];
            end
        end
    end

    // ---------------- channel datapath ----------------
    for (genvar i = 0; i < NUM_CH; i++) begin : g_src
        evr_src_pick #(
            .NUM_PROD (NUM_PROD),
            .NUM_SIG  (NUM_SIG)
        ) u_pick (
            .clk      (clk),
            .rst      (rst),
            .sig_sel  (ctrl_q[i].sig),
            .src_sel  (ctrl_q[i].src),
            .prod_vec (prod_sig_i),
            .a_out    (a_sel[i])
        );
    end

    // Plain channels: operand A plus software forcing
    assign plain_v = a_sel[FIRST_LOGIC-1:0] | level_q[FIRST_LOGIC-1:0]
                   | pulse_now[FIRST_LOGIC-1:0];

    // Operand B pool: plain channels unregistered, logic channels registered
    assign b_pool = {ch_q[NUM_CH-1:FIRST_LOGIC], plain_v};

    for (genvar j = 0; j < NUM_LOGIC; j++) begin : g_logic
        localparam int CH = FIRST_LOGIC + j;
        logic b_val;

        evr_pick_n #(
            .N     (NUM_CH),
            .SEL_W (AUX_W)
        ) u_aux (
            .clk    (clk),
            .rst    (rst),
            .sel    (ctrl_q[CH].aux),
            .in_vec (b_pool),
            .out    (b_val)
        );

        assign logic_v[j] = lut2(ctrl_q[CH].fn, a_sel[CH], b_val)
                          | level_q[CH] | pulse_now[CH];

        // R5: constant-zero code with no forcing leaves the channel low
        p_fn_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[CH].fn == FN_ZERO && !level_q[CH] && !pulse_now[CH]) |=> !ch_q[CH]);

        // R5: constant-one code always drives the channel high
        p_fn_one_high_r5: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[CH].fn == FN_ONE) |=> ch_q[CH]);
    end

    assign ch_next = {logic_v, plain_v};

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q  <= '0;
            val_q <= '0;
        end else begin
            ch_q  <= ch_next;
            val_q <= ch_q;
        end
    end

    assign chan_o = ch_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_force_chk
        // R8: a written pulse bit shows on the output at the next edge
        p_pulse_seen_r8: assert property (@(posedge clk) disable iff (rst)
            pulse_now[i] |=> ch_q[i]);
        // R7: a set level bit holds the output high
        p_level_held_r7: assert property (@(posedge clk) disable iff (rst)
            level_q[i] |=> ch_q[i]);
    end

    // R1: reset leaves outputs, read-back and level cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ch_q == '0 && val_q == '0 && level_q == '0));

    // ---------------- consumers ----------------
    for (genvar k = 0; k < NUM_CONS; k++) begin : g_cons
        evr_pick_n #(
            .N     (NUM_CH),
            .SEL_W (CSEL_W)
        ) u_async (
            .clk    (clk),
            .rst    (rst),
            .sel    (csel_q[k]),
            .in_vec (ch_q),
            .out    (cons_async_o[k])
        );
    end

    for (genvar m = 0; m < NUM_SCONS; m++) begin : g_scons
        evr_pick_n #(
            .N     (NUM_SYNC),
            .SEL_W (SSEL_W)
        ) u_sync (
            .clk    (clk),
            .rst    (rst),
            .sel    (ssel_q[m]),
            .in_vec (sync_ch_i),
            .out    (cons_sync_o[m])
        );
    end

    // ---------------- read port ----------------
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_LEVEL) rd_data[NUM_CH-1:0] = level_q;
        if (rd_addr == ADDR_VALUE) rd_data[NUM_CH-1:0] = val_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_CTRL_BASE + REG_ADDR_W'(i))
                rd_data = pack_ctrl(ctrl_q[i]);
        end
        for (int k = 0; k < NUM_CONS; k++) begin
            if (rd_addr == ADDR_CONS_BASE + REG_ADDR_W'(k))
                rd_data[CSEL_LSB +: CSEL_W] = csel_q[k];
        end
        for (int m = 0; m < NUM_SCONS; m++) begin
            if (rd_addr == ADDR_CONS_BASE + REG_ADDR_W'(FIRST_SCONS + m))
                rd_data[SSEL_LSB +: SSEL_W] = ssel_q[m];
        end
    end

endmodule

// File: tb/evr_router_bench.sv
module evr_router_bench;

    localparam logic [5:0] A_LEVEL = 6'h00;
    localparam logic [5:0] A_PULSE = 6'h01;
    localparam logic [5:0] A_VALUE = 6'h02;
    localparam logic [5:0] A_CTRL  = 6'h10;
    localparam logic [5:0] A_CONS  = 6'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [27:0] prod_sig_i = '0;
    logic [3:0]  sync_ch_i = '0;
    logic [11:0] chan_o;
    logic [5:0]  cons_async_o;
    logic [1:0]  cons_sync_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    evr_router u_evr_router (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .prod_sig_i   (prod_sig_i),
        .sync_ch_i    (sync_ch_i),
        .chan_o       (chan_o),
        .cons_async_o (cons_async_o),
        .cons_sync_o  (cons_sync_o)
    );

    function automatic logic [31:0] mk_ctrl(int sig, int src, int fn, int aux);
        return (32'(aux) << 24) | (32'(fn) << 16) | (32'(src) << 8) | 32'(sig);
    endfunction

    function automatic logic ref_op(int code, logic a, logic b);
        case (code)
            0:  return 1'b0;
            1:  return !(a | b);
            2:  return !a & b;
            3:  return !a;
            4:  return a & !b;
            5:  return !b;
            6:  return a ^ b;
            7:  return !(a & b);
            8:  return a & b;
            9:  return !(a ^ b);
            10: return b;
            11: return !a | b;
            12: return a;
            13: return a | !b;
            14: return a | b;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] addr, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [5:0] addr, output logic [31:0] data);
        rd_addr = addr;
        #1 data = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; prod_sig_i = '0; sync_ch_i = '0; rd_addr = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 chan_o", 32'(chan_o), 0);
        chk("R1 cons_async_o", 32'(cons_async_o), 0);
        rd(A_LEVEL, d);    chk("R1 level", d, 0);
        rd(A_VALUE, d);    chk("R1 value", d, 0);
        rd(A_CTRL + 6'd9, d); chk("R1 ctrl9", d, 0);
        rd(A_CONS + 6'd5, d); chk("R1 cons5", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(A_LEVEL, 32'hFFFF_FFFF);
        rd(A_LEVEL, d); chk("R2 level rw", d, 32'h0000_0FFF);
        wr(A_LEVEL, 0);
        wr(A_CTRL + 6'd3, 32'hFFFF_FFFF);
        rd(A_CTRL + 6'd3, d); chk("R2 ctrl fields", d, 32'h0F0F_7F07);
        wr(A_CONS + 6'd5, 32'hFFFF_FFFF);
        rd(A_CONS + 6'd5, d); chk("R2 sync consumer fields", d, 32'h0000_030F);
        wr(A_CONS + 6'd0, 32'hFFFF_FFFF);
        rd(A_CONS + 6'd0, d); chk("R2 async consumer fields", d, 32'h0000_000F);
        step(3);
        wr(A_VALUE, 32'h0000_0FFF);
        step(2);
        rd(A_VALUE, d); chk("R2 value write ignored", d, 0);
        rd(A_PULSE, d); chk("R2 pulse reads zero", d, 0);
    endtask

    task automatic t_source();
        do_reset();
        wr(A_CTRL + 6'd1, mk_ctrl(3, 2, 0, 0));   // producer 2, signal 3 -> bit 16
        step(1);
        prod_sig_i = 28'(1) << 16;
        #1 chk("R12 no change before edge", 32'(chan_o[1]), 0);
        step(1);
        chk("R3 selected bit high", 32'(chan_o[1]), 1);
        chk("R12 after one edge", 32'(chan_o[1]), 1);
        prod_sig_i = ~(28'(1) << 16);
        step(1);
        chk("R3 other bits ignored", 32'(chan_o[1]), 0);
        prod_sig_i = '1;
        wr(A_CTRL + 6'd1, mk_ctrl(3, 5, 0, 0));
        step(1);
        chk("R3 source out of range", 32'(chan_o[1]), 0);
        wr(A_CTRL + 6'd1, mk_ctrl(0, 2, 0, 0));
        step(1);
        chk("R3 signal select zero", 32'(chan_o[1]), 0);
        prod_sig_i = '0;
        wr(A_CTRL + 6'd1, mk_ctrl(3, 2, 15, 2));
        step(1);
        chk("R4 plain channel ignores function", 32'(chan_o[1]), 0);
    endtask

    task automatic t_logic();
        do_reset();
        wr(A_CTRL + 6'd0, mk_ctrl(1, 0, 0, 0));   // ch0 A = bit0 (B source)
        for (int code = 0; code < 16; code++) begin
            wr(A_CTRL + 6'd8, mk_ctrl(2, 0, code, 0)); // ch8 A = bit1, B = ch0
            for (int ab = 0; ab < 4; ab++) begin
                prod_sig_i = 28'(ab);               // bit1 = a, bit0 = b
                step(1);
                chk($sformatf("R5 code %0d ab %0d", code, ab), 32'(chan_o[8]),
                    32'(ref_op(code, ab[1], ab[0])));
            end
        end
    endtask

    task automatic t_aux();
        logic x;
        do_reset();
        wr(A_LEVEL, 32'h0FF);
        wr(A_CTRL + 6'd8, mk_ctrl(0, 0, 10, 13));
        step(1);
        chk("R6 aux out of range gives 0", 32'(chan_o[8]), 0);
        wr(A_CTRL + 6'd8, mk_ctrl(0, 0, 10, 3));
        step(1);
        chk("R6 aux plain channel", 32'(chan_o[8]), 1);
        wr(A_LEVEL, 0);
        wr(A_CTRL + 6'd8, mk_ctrl(2, 0, 12, 0));
        wr(A_CTRL + 6'd9, mk_ctrl(0, 0, 10, 8));
        step(2);
        prod_sig_i = 28'h2;
        step(1);
        chk("R6 source channel first", 32'(chan_o[8]), 1);
        chk("R6 registered aux lags", 32'(chan_o[9]), 0);
        step(1);
        chk("R6 registered aux follows", 32'(chan_o[9]), 1);
        prod_sig_i = 28'h1;
        wr(A_CTRL + 6'd10, mk_ctrl(1, 0, 6, 10));
        step(1);
        x = chan_o[10];
        step(1);
        chk("R6 self aux toggles", 32'(chan_o[10]), 32'(!x));
        step(1);
        chk("R6 self aux toggles back", 32'(chan_o[10]), 32'(x));
    endtask

    task automatic t_level();
        do_reset();
        wr(A_LEVEL, 32'h040);
        chk("R7 level not yet", 32'(chan_o[6]), 0);
        step(1);
        chk("R7 level high", 32'(chan_o[6]), 1);
        step(3);
        chk("R7 level held", 32'(chan_o[6]), 1);
        wr(A_LEVEL, 0);
        chk("R7 last cycle of level", 32'(chan_o[6]), 1);
        step(1);
        chk("R7 level released", 32'(chan_o[6]), 0);
        wr(A_LEVEL, 32'h800);
        step(1);
        chk("R7 level ORed on logic channel", 32'(chan_o[11]), 1);
    endtask

    task automatic t_pulse();
        logic [31:0] d;
        do_reset();
        wr(A_PULSE, 32'h810);
        chk("R8 pulse high", 32'(chan_o), 32'h810);
        rd(A_VALUE, d); chk("R9 value not yet", d, 0);
        step(1);
        chk("R8 pulse one cycle", 32'(chan_o), 0);
        rd(A_VALUE, d); chk("R9 value lags one cycle", d, 32'h810);
        step(1);
        rd(A_VALUE, d); chk("R9 value clears", d, 0);
    endtask

    task automatic t_cons();
        do_reset();
        wr(A_LEVEL, 32'h020);
        step(1);
        wr(A_CONS + 6'd2, 32'h5);
        chk("R10 consumer follows channel 5", 32'(cons_async_o[2]), 1);
        chk("R10 consumer on channel 0", 32'(cons_async_o[3]), 0);
        wr(A_LEVEL, 32'hFFF);
        step(1);
        wr(A_CONS + 6'd2, 32'hC);
        chk("R10 select 12 gives 0", 32'(cons_async_o[2]), 0);
        wr(A_CONS + 6'd2, 32'hF);
        chk("R10 select 15 gives 0", 32'(cons_async_o[2]), 0);
        wr(A_CONS + 6'd2, 32'hB);
        chk("R10 select 11", 32'(cons_async_o[2]), 1);
        wr(A_CONS + 6'd4, 32'h207);
        wr(A_CONS + 6'd5, 32'h300);
        chk("R11 async part independent", 32'(cons_async_o[4]), 1);
        sync_ch_i = 4'b0100;
        #1 chk("R11 sync sel 2", 32'(cons_sync_o), 32'b01);
        sync_ch_i = 4'b1000;
        #1 chk("R11 sync sel 3", 32'(cons_sync_o), 32'b10);
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        wr(A_LEVEL, 32'hFFF);
        step(2);
        do_reset();
        chk("R1 outputs cleared by reset", 32'(chan_o), 0);
        rd(A_LEVEL, d); chk("R1 level cleared by reset", d, 0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_source();
        t_logic();
        t_aux();
        t_level();
        t_pulse();
        t_cons();
        t_reset_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule